// File: doc/BRIEF.md
# Odd-Even Merging Network

This block merges two lists that are each already in nondecreasing order into one nondecreasing list of twice the length. It is a pure comparator network with no state. The list `x` is split into its odd-position and even-position elements, and so is `y`. A half-size merger combines the two odd-position sets into a list `u`. A second half-size merger runs in parallel and combines the two even-position sets into a list `v`. One column of `M-1` comparators then pairs each `u` element with the `v` element one place before it. The first `u` element and the last `v` element pass straight to the ends of the output. This construction recurses down to single two-input comparators. For `2M` outputs the network is `log2(2M)` comparators deep.

Elements are unsigned, `W` bits wide, and packed into flat vectors. Element `k` (counting from 0 as the first) sits at bits `[k*W +: W]`. `M` must be a power of two. The block does not check that its inputs are sorted.

The data path is wrapped in a valid/ready stream handshake with no storage. `out_valid` follows `in_valid` in the same cycle, and `in_ready` follows `out_ready` in the same cycle. A transfer on the input side is therefore the same transfer on the output side. When the consumer holds `out_ready` low, back-pressure reaches the producer in the same cycle, and the producer must hold its data and `in_valid` steady until the transfer completes.

Top module: `oem_merge_stream`

## Requirements
- R1: When both input lists are nondecreasing, `z_data` is nondecreasing from element 0 to element 2M-1.
- R2: `z_data` holds exactly the multiset of the 2M input elements, i.e. it equals the sorted concatenation of `x_data` and `y_data`.
- R3: Element 0 of `z_data` is the smaller of the first elements of `x` and `y`, and element 2M-1 is the larger of their last elements.
- R4: Elements compare as unsigned numbers, so a value with its most significant bit set orders above every value without it.
- R5: `out_valid` equals `in_valid` in the same cycle.
- R6: `in_ready` equals `out_ready` in the same cycle, giving back-pressure with no buffering.
- R7: `z_data` depends only on `x_data` and `y_data`, and is the correct merge even while `in_valid` is low.
- R8: Corner patterns merge correctly: all keys equal, all of `x` below all of `y`, and all of `y` below all of `x`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| in_valid | input | 1 | Producer has a list pair on `x_data`/`y_data` |
| in_ready | output | 1 | Block can accept (mirrors `out_ready`) |
| x_data | input | M*W | First sorted list, element 0 in the low bits |
| y_data | input | M*W | Second sorted list, element 0 in the low bits |
| out_valid | output | 1 | Merged list on `z_data` is valid |
| out_ready | input | 1 | Consumer accepts the merged list |
| z_data | output | 2*M*W | Merged nondecreasing list, element 0 in the low bits |

## Verification
The checker re-evaluates four properties whenever the inputs are sorted: output order, conservation of the element sum, the two end elements, and the handshake mirroring. Sum conservation only shows that no value was lost in aggregate. Full multiset equality against a sorted reference is shown only by the bench. The bench runs every sorted pair in a 2-bit, two-element configuration and random sorted pairs in the default configuration. It also runs the unsigned top-bit patterns and the equal and disjoint-range lists. Only the bench shows that the data result does not depend on `in_valid`.

// File: rtl/oem_pkg.sv
package oem_pkg;
  // Default configuration: 8-bit keys, two lists of four (eight outputs).
  parameter int unsigned OEM_DEF_W = 8;
  parameter int unsigned OEM_DEF_M = 4;
endpackage

// File: rtl/oem_cmp.sv
// Two-input compare-exchange: smaller value to lo, larger to hi.
// On a tie the a-side value is routed to lo.
module oem_cmp #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] lo,
  output logic [W-1:0] hi
);
  logic b_less;
  assign b_less = (b < a);
  assign lo = b_less ? b : a;
  assign hi = b_less ? a : b;
endmodule

// File: rtl/oem_col.sv
// Final combine column of an (M,M) merger: u[0] and v[M-1] pass through,
// u[i] is compared with v[i-1] for i = 1..M-1.
module oem_col #(
  parameter int unsigned W = 8,
  parameter int unsigned M = 4
) (
  input  logic [M*W-1:0]   u,
  input  logic [M*W-1:0]   v,
  output logic [2*M*W-1:0] z
);
  localparam int unsigned LAST = 2*M - 1;

  assign z[0 +: W]      = u[0 +: W];
  assign z[LAST*W +: W] = v[(M-1)*W +: W];

  for (genvar i = 1; i < M; i++) begin : g_pair
    oem_cmp #(.W(W)) u_cmp (
      .a  (u[i*W +: W]),
      .b  (v[(i-1)*W +: W]),
      .lo (z[(2*i-1)*W +: W]),
      .hi (z[(2*i)*W +: W])
    );
  end
endmodule

// File: rtl/oem_merge.sv
// Recursive (M,M) odd-even merger. M must be a power of two.
module oem_merge #(
  parameter int unsigned W = 8,
  parameter int unsigned M = 4
) (
  input  logic [M*W-1:0]   a,
  input  logic [M*W-1:0]   b,
  output logic [2*M*W-1:0] z
);
  if (M == 1) begin : g_base
    oem_cmp #(.W(W)) u_cmp (
      .a  (a),
      .b  (b),
      .lo (z[0 +: W]),
      .hi (z[W +: W])
    );
  end else begin : g_split
    localparam int unsigned H = M / 2;

    logic [H*W-1:0] a_odd, a_even, b_odd, b_even;
    logic [M*W-1:0] u_lst, v_lst;

    // Position 1,3,5.. (one-based) are the even zero-based slots.
    for (genvar k = 0; k < H; k++) begin : g_deal
      assign a_odd[k*W +: W]  = a[(2*k)*W +: W];
      assign a_even[k*W +: W] = a[(2*k+1)*W +: W];
      assign b_odd[k*W +: W]  = b[(2*k)*W +: W];
      assign b_even[k*W +: W] = b[(2*k+1)*W +: W];
    end

    oem_merge #(.W(W), .M(H)) u_odd (
      .a (a_odd),
      .b (b_odd),
      .z (u_lst)
    );

    oem_merge #(.W(W), .M(H)) u_even (
      .a (a_even),
      .b (b_even),
      .z (v_lst)
    );

    oem_col #(.W(W), .M(M)) u_col (
      .u (u_lst),
      .v (v_lst),
      .z (z)
    );
  end
endmodule

// File: rtl/oem_merge_stream.sv
// Stream wrapper: zero-latency, zero-storage valid/ready around the network.
module oem_merge_stream #(
  parameter int unsigned W = oem_pkg::OEM_DEF_W,
  parameter int unsigned M = oem_pkg::OEM_DEF_M
) (
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [M*W-1:0]   x_data,
  input  logic [M*W-1:0]   y_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [2*M*W-1:0] z_data
);
  assign out_valid = in_valid;
  assign in_ready  = out_ready;

  oem_merge #(.W(W), .M(M)) u_net (
    .a (x_data),
    .b (y_data),
    .z (z_data)
  );
endmodule

// File: rtl/oem_merge_chk.sv
module oem_merge_chk #(
  parameter int unsigned W = 8,
  parameter int unsigned M = 4
) (
  input logic             in_valid,
  input logic             in_ready,
  input logic [M*W-1:0]   x_data,
  input logic [M*W-1:0]   y_data,
  input logic             out_valid,
  input logic             out_ready,
  input logic [2*M*W-1:0] z_data
);
  localparam int unsigned N  = 2 * M;
  localparam int unsigned SW = W + $clog2(N) + 1;

  logic          in_sorted;
  logic          out_sorted;
  logic [SW-1:0] sum_in;
  logic [SW-1:0] sum_out;
  logic [W-1:0]  want_first;
  logic [W-1:0]  want_last;

  always_comb begin
    in_sorted = 1'b1;
    sum_in    = '0;
    for (int i = 0; i < M; i++) begin
      sum_in = sum_in + SW'(x_data[i*W +: W]) + SW'(y_data[i*W +: W]);
      if (i > 0) begin
        if (x_data[i*W +: W] < x_data[(i-1)*W +: W]) in_sorted = 1'b0;
        if (y_data[i*W +: W] < y_data[(i-1)*W +: W]) in_sorted = 1'b0;
      end
    end
    out_sorted = 1'b1;
    sum_out    = '0;
    for (int i = 0; i < N; i++) begin
      sum_out = sum_out + SW'(z_data[i*W +: W]);
      if (i > 0 && z_data[i*W +: W] < z_data[(i-1)*W +: W]) out_sorted = 1'b0;
    end
    want_first = (x_data[0 +: W] < y_data[0 +: W]) ? x_data[0 +: W] : y_data[0 +: W];
    want_last  = (x_data[(M-1)*W +: W] > y_data[(M-1)*W +: W]) ?
                 x_data[(M-1)*W +: W] : y_data[(M-1)*W +: W];
  end

  always_comb begin
    if (in_valid && in_sorted) begin
      p_out_sorted_r1: assert (out_sorted)
        else $error("merged output out of order");
      p_sum_kept_r2: assert (sum_in == sum_out)
        else $error("element sum not conserved");
      p_end_elems_r3: assert (z_data[0 +: W] == want_first &&
                              z_data[(N-1)*W +: W] == want_last)
        else $error("end elements wrong");
    end
    p_valid_mirror_r5: assert (out_valid == in_valid)
      else $error("out_valid does not follow in_valid");
    p_ready_mirror_r6: assert (in_ready == out_ready)
      else $error("in_ready does not follow out_ready");
  end
endmodule

bind oem_merge_stream oem_merge_chk #(.W(W), .M(M)) u_chk (.*);

// File: tb/oem_merge_stream_tb_top.sv
`timescale 1ns/1ps
module oem_merge_stream_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  int n_chk  = 0;
  int n_fail = 0;

  // Default configuration: W=8, M=4
  logic        b_iv, b_ir, b_ov, b_or;
  logic [31:0] b_x, b_y;
  logic [63:0] b_z;

  oem_merge_stream #(.W(8), .M(4)) dut_i (
    .in_valid (b_iv), .in_ready (b_ir),
    .x_data   (b_x),  .y_data   (b_y),
    .out_valid(b_ov), .out_ready(b_or),
    .z_data   (b_z)
  );

  // Small configuration for exhaustive sweep: W=2, M=2
  logic       s_iv, s_ir, s_ov, s_or;
  logic [3:0] s_x, s_y;
  logic [7:0] s_z;

  oem_merge_stream #(.W(2), .M(2)) dut_s_i (
    .in_valid (s_iv), .in_ready (s_ir),
    .x_data   (s_x),  .y_data   (s_y),
    .out_valid(s_ov), .out_ready(s_or),
    .z_data   (s_z)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic sort_n(inout int r[8], input int n);
    for (int i = 1; i < n; i++) begin
      int k;
      int j;
      k = r[i];
      j = i - 1;
      while (j >= 0 && r[j] > k) begin
        r[j+1] = r[j];
        j--;
      end
      r[j+1] = k;
    end
  endtask

  // Compare merged output against the arithmetic reference.
  task automatic verify(input int m, input int xs[4], input int ys[4],
                        input int zs[8], input string ctx);
    int r[8];
    int bad_o;
    int bad_r;
    int lo_e;
    int hi_e;
    for (int i = 0; i < 8; i++) r[i] = 0;
    for (int i = 0; i < m; i++) begin
      r[i]   = xs[i];
      r[m+i] = ys[i];
    end
    sort_n(r, 2*m);
    bad_o = -1;
    for (int i = 1; i < 2*m; i++) if (bad_o < 0 && zs[i] < zs[i-1]) bad_o = i;
    chk(bad_o < 0, "R1", {ctx, " order"}, (bad_o < 0) ? 0 : zs[bad_o], (bad_o < 0) ? 0 : zs[bad_o-1]);
    bad_r = -1;
    for (int i = 0; i < 2*m; i++) if (bad_r < 0 && zs[i] != r[i]) bad_r = i;
    chk(bad_r < 0, "R2", {ctx, " contents"}, (bad_r < 0) ? 0 : zs[bad_r], (bad_r < 0) ? 0 : r[bad_r]);
    lo_e = (xs[0] < ys[0]) ? xs[0] : ys[0];
    hi_e = (xs[m-1] > ys[m-1]) ? xs[m-1] : ys[m-1];
    chk(zs[0] == lo_e, "R3", {ctx, " first"}, zs[0], lo_e);
    chk(zs[2*m-1] == hi_e, "R3", {ctx, " last"}, zs[2*m-1], hi_e);
  endtask

  task automatic run_big(input int xs[4], input int ys[4], input string ctx);
    int zs[8];
    @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      b_x[i*8 +: 8] = 8'(xs[i]);
      b_y[i*8 +: 8] = 8'(ys[i]);
    end
    #1;
    for (int i = 0; i < 8; i++) zs[i] = int'(b_z[i*8 +: 8]);
    verify(4, xs, ys, zs, ctx);
  endtask

  task automatic run_small(input int xs[4], input int ys[4]);
    int zs[8];
    @(negedge clk);
    for (int i = 0; i < 2; i++) begin
      s_x[i*2 +: 2] = 2'(xs[i]);
      s_y[i*2 +: 2] = 2'(ys[i]);
    end
    #1;
    for (int i = 0; i < 8; i++) zs[i] = 0;
    for (int i = 0; i < 4; i++) zs[i] = int'(s_z[i*2 +: 2]);
    verify(2, xs, ys, zs, "small");
  endtask

  task automatic rand_sorted(output int v[4]);
    int r[8];
    for (int i = 0; i < 8; i++) r[i] = (i < 4) ? int'($urandom_range(0, 255)) : 0;
    sort_n(r, 4);
    for (int i = 0; i < 4; i++) v[i] = r[i];
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int xs[4];
    int ys[4];
    b_iv = 1'b0; b_or = 1'b0; b_x = '0; b_y = '0;
    s_iv = 1'b0; s_or = 1'b0; s_x = '0; s_y = '0;
    #1;
    // Idle state: nothing valid, no ready
    chk(b_ov == 1'b0, "R5", "idle out_valid", longint'(b_ov), 0);
    chk(b_ir == 1'b0, "R6", "idle in_ready", longint'(b_ir), 0);

    // R5 / R6: every handshake combination on both instances
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      b_iv = c[0]; b_or = c[1];
      s_iv = c[1]; s_or = c[0];
      #1;
      chk(b_ov == c[0], "R5", "out_valid big", longint'(b_ov), longint'(c[0]));
      chk(b_ir == c[1], "R6", "in_ready big", longint'(b_ir), longint'(c[1]));
      chk(s_ov == c[1], "R5", "out_valid small", longint'(s_ov), longint'(c[1]));
      chk(s_ir == c[0], "R6", "in_ready small", longint'(s_ir), longint'(c[0]));
    end

    b_iv = 1'b1; b_or = 1'b1; s_iv = 1'b1; s_or = 1'b1;

    // Exhaustive sweep of all sorted pairs in the 2-bit, two-element setup
    for (int x0 = 0; x0 < 4; x0++)
      for (int x1 = x0; x1 < 4; x1++)
        for (int y0 = 0; y0 < 4; y0++)
          for (int y1 = y0; y1 < 4; y1++) begin
            xs = '{x0, x1, 0, 0};
            ys = '{y0, y1, 0, 0};
            run_small(xs, ys);
          end

    // R8 corner patterns
    xs = '{77, 77, 77, 77}; ys = '{77, 77, 77, 77};
    run_big(xs, ys, "R8 all equal");
    xs = '{0, 1, 2, 3}; ys = '{250, 251, 252, 253};
    run_big(xs, ys, "R8 x below y");
    xs = '{200, 210, 220, 230}; ys = '{5, 6, 7, 8};
    run_big(xs, ys, "R8 y below x");
    xs = '{1, 3, 5, 7}; ys = '{2, 4, 6, 8};
    run_big(xs, ys, "R8 interleaved");

    // R4 unsigned ordering with top bit set
    xs = '{1, 2, 3, 4}; ys = '{128, 200, 255, 255};
    run_big(xs, ys, "R4 msb");
    chk(b_z[56 +: 8] == 8'd255, "R4", "top element", longint'(b_z[56 +: 8]), 255);
    chk(b_z[32 +: 8] == 8'd128, "R4", "msb after small", longint'(b_z[32 +: 8]), 128);
    xs = '{127, 128, 129, 255}; ys = '{0, 127, 128, 254};
    run_big(xs, ys, "R4 boundary");

    // R7: data path independent of in_valid
    @(negedge clk);
    b_iv = 1'b0; b_or = 1'b0;
    xs = '{10, 20, 30, 40}; ys = '{15, 25, 35, 45};
    run_big(xs, ys, "R7 invalid");
    chk(b_z == 64'h2d28231e19140f0a, "R7", "z while idle", longint'(b_z[31:0]), longint'(32'h19140f0a));
    b_iv = 1'b1; b_or = 1'b1;

    // Random sorted pairs, default configuration
    for (int t = 0; t < 400; t++) begin
      rand_sorted(xs);
      rand_sorted(ys);
      run_big(xs, ys, "random");
    end

    @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule